// File: doc/BRIEF.md
# Multi-Mode Serial Receiver with Status Flags

This block turns a serial bit stream into bytes. It supports three framings. In asynchronous normal mode the frame is a start bit, eight bit slots and a stop bit. The last slot may carry parity in place of the top data bit. Asynchronous multiprocessor mode adds an address/data marker between the data and the stop bit. In clocked synchronous mode eight bits are taken on the rising edges of an external serial clock, with no start or stop bit. Asynchronous bits are sampled at mid-bit. The timing comes from a 16x oversampling tick that a baud generator outside the block supplies.

When a word completes, the receiver runs a two-step completion sequence. First it raises any error that applies: parity, framing or overrun. One cycle later it loads the holding register and raises the data-full flag. An interrupt request follows the flags one cycle later when it is enabled. A host strobe that reads the holding register clears data-full. A second strobe clears the three error flags. While any error flag is set, the host treats the held byte as invalid.

The controller has seven named states, and each moves on only as stated here:
- IDLE waits for a low line in the asynchronous modes, and goes to START. In synchronous mode a clock edge takes the first bit and the controller goes to DATA.
- START confirms the low level at half a bit time, then goes to DATA, or returns to IDLE on a glitch.
- DATA shifts in eight slots. At the end it goes to ADDR in multiprocessor mode, to STOP in normal mode and to FLAG in synchronous mode.
- ADDR samples the marker bit and goes to STOP.
- STOP samples the stop bit and goes to FLAG.
- FLAG raises the error flags.
- LOAD commits the byte and returns to IDLE.

Top module: `mmode_uart_rx`

## Requirements
- R1: In mode 0 and mode 1, the byte (LSB first) is loaded into `data_out` and `full` becomes 1 after the stop bit has been sampled at its midpoint.
- R2: When mode[1] is 1 (mode 2 or 3), each rising edge of `sclk_in` samples `rx_in`. After the eighth edge the byte is loaded and `full` is set, with no stop bit.
- R3: Within one completion, every error flag that applies rises exactly one cycle before `full` rises, and never in the same cycle.
- R4: In mode 0 with `par_en`=1, slot 7 is a parity bit over bits 0..6. The total count of ones over bits 0..6 plus the parity bit is even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets `perr`, and `data_out[7]` reads 0.
- R5: In mode 1 the bit after slot 7 is exposed on `adr_bit` together with the byte. All eight slots are data, and `perr` never sets, whatever `par_en` is.
- R6: In synchronous mode only `oerr` can set. `perr` and `ferr` never set.
- R7: If a word completes while `full` is 1, `oerr` is set, the new word is discarded, and `data_out` keeps the old byte.
- R8: In mode 0 and mode 1, a stop bit sampled low sets `ferr`. The byte is still loaded.
- R9: A low pulse on `rx_in` that is shorter than half a bit time is not taken as a start bit. A valid frame that follows it is received correctly.
- R10: A one-cycle `rd_data` clears `full`, and a one-cycle `clr_err` clears `perr`, `oerr` and `ferr`. Neither strobe changes `data_out`.
- R11: `irq` equals, one cycle later, `rie` AND (`full` OR `perr` OR `oerr` OR `ferr`). It stays 0 while `rie`=0.
- R12: After reset, `data_out`, `adr_bit`, `full`, `perr`, `oerr`, `ferr` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per asynchronous bit time |
| rx_in | input | 1 | Serial data line |
| sclk_in | input | 1 | Serial clock for synchronous mode |
| mode | input | 2 | 0 async normal, 1 async multiprocessor, 2 or 3 synchronous |
| par_en | input | 1 | Use slot 7 as parity in mode 0 |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rie | input | 1 | Receive interrupt enable |
| rd_data | input | 1 | Host read strobe; clears data-full |
| clr_err | input | 1 | Strobe that clears the three error flags |
| data_out | output | 8 | Holding register |
| adr_bit | output | 1 | Address/data marker of the last multiprocessor frame |
| full | output | 1 | Data-full flag |
| perr | output | 1 | Parity error flag |
| oerr | output | 1 | Overrun error flag |
| ferr | output | 1 | Framing error flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions check four things on every cycle:
- No error flag rises in the same cycle as `full`.
- Parity errors arise only in mode 0, and framing errors only in an asynchronous mode.
- An overrun is only ever raised while `full` is already set, and the holding register never changes while `full` is held.
- The interrupt line tracks the enabled flags with one cycle of delay.

Only the bench's scenarios can show the rest. That covers bit order, parity polarity, marker capture, mid-bit sampling, glitch rejection and the byte values. The bench sweeps every byte in mode 0 and in synchronous mode, and strided sets of bytes for parity and multiprocessor frames.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_STOP,
        ST_FLAG,
        ST_LOAD
    } rx_state_t;

    localparam logic [1:0] MODE_ASYNC = 2'd0;
    localparam logic [1:0] MODE_MPROC = 2'd1;

endpackage

// File: rtl/rxm_front.sv
module rxm_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic sclk_in,
    output logic rx_s,
    output logic sclk_rise
);

    logic [SYNC_STAGES-1:0] rx_pipe;
    logic [SYNC_STAGES-1:0] ck_pipe;
    logic                   ck_prev;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rx_pipe[g] <= 1'b1;
                    ck_pipe[g] <= 1'b0;
                end else begin
                    rx_pipe[g] <= rx_in;
                    ck_pipe[g] <= sclk_in;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rx_pipe[g] <= 1'b1;
                    ck_pipe[g] <= 1'b0;
                end else begin
                    rx_pipe[g] <= rx_pipe[g-1];
                    ck_pipe[g] <= ck_pipe[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ck_prev <= 1'b0;
        else        ck_prev <= ck_pipe[SYNC_STAGES-1];
    end

    assign rx_s      = rx_pipe[SYNC_STAGES-1];
    assign sclk_rise = ck_pipe[SYNC_STAGES-1] & ~ck_prev;

endmodule

// File: rtl/rxm_fsm.sv
module rxm_fsm
    import rxm_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_s,
    input  logic          sclk_rise,
    input  logic [1:0]    mode,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          flag_stb,
    output logic          load_stb,
    output logic          perr_hit,
    output logic          ferr_hit,
    output logic [DW-1:0] word,
    output logic          adr_bit
);

    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DW + 1);
    localparam int HALF = OSR / 2 - 1;

    rx_state_t     state_q, state_d;
    logic [CW-1:0] tcnt_q;
    logic [BW-1:0] bcnt_q;
    logic [DW-1:0] sh_q;
    logic          adr_q;
    logic          stop_bad_q;

    logic sync_m;
    logic mid_bit;
    logic mid_start;
    logic last_bit;
    logic take_bit;
    logic par_mode;

    assign sync_m    = mode[1];
    assign mid_bit   = os_tick && (tcnt_q == CW'(OSR - 1));
    assign mid_start = os_tick && (tcnt_q == CW'(HALF));
    assign last_bit  = (bcnt_q == BW'(DW - 1));
    assign take_bit  = sync_m ? sclk_rise : mid_bit;
    assign par_mode  = (mode == MODE_ASYNC) && par_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        flag_stb = 1'b0;
        load_stb = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_m) begin
                    if (sclk_rise) state_d = ST_DATA;
                end else if (!rx_s) begin
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (mid_start) state_d = rx_s ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (take_bit && last_bit) begin
                    if (sync_m)                  state_d = ST_FLAG;
                    else if (mode == MODE_MPROC) state_d = ST_ADDR;
                    else                         state_d = ST_STOP;
                end
            end
            ST_ADDR: begin
                if (mid_bit) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (mid_bit) state_d = ST_FLAG;
            end
            ST_FLAG: begin
                flag_stb = 1'b1;
                state_d  = ST_LOAD;
            end
            ST_LOAD: begin
                load_stb = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        perr_hit = par_mode && (sh_q[DW-1] != ((^sh_q[DW-2:0]) ^ par_odd));
        ferr_hit = !sync_m && stop_bad_q;
        word     = par_mode ? {1'b0, sh_q[DW-2:0]} : sh_q;
        adr_bit  = adr_q;
    end

    // oversampling counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
        end else if (state_q == ST_START || state_q == ST_ADDR || state_q == ST_STOP
                     || (state_q == ST_DATA && !sync_m)) begin
            if ((state_q == ST_START && mid_start) || mid_bit) tcnt_q <= '0;
            else if (os_tick)                                  tcnt_q <= tcnt_q + 1'b1;
        end else begin
            tcnt_q <= '0;
        end
    end

    // shift register, bit counter, marker and stop capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q     <= '0;
            sh_q       <= '0;
            adr_q      <= 1'b0;
            stop_bad_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    adr_q      <= 1'b0;
                    stop_bad_q <= 1'b0;
                    if (sync_m && sclk_rise) begin
                        sh_q   <= {rx_s, sh_q[DW-1:1]};
                        bcnt_q <= BW'(1);
                    end else begin
                        bcnt_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (take_bit) begin
                        sh_q   <= {rx_s, sh_q[DW-1:1]};
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (mid_bit) adr_q <= rx_s;
                end
                ST_STOP: begin
                    if (mid_bit) stop_bad_q <= !rx_s;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rxm_flags.sv
module rxm_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag_stb,
    input  logic          load_stb,
    input  logic          perr_hit,
    input  logic          ferr_hit,
    input  logic [DW-1:0] word,
    input  logic          adr_in,
    input  logic          rd_data,
    input  logic          clr_err,
    input  logic          rie,
    output logic [DW-1:0] data_out,
    output logic          adr_out,
    output logic          full,
    output logic          perr,
    output logic          oerr,
    output logic          ferr,
    output logic          irq
);

    logic [DW-1:0] data_q;
    logic          adr_q;
    logic          full_q, perr_q, oerr_q, ferr_q, ovr_q, irq_q;
    logic          commit;

    assign commit = load_stb && !ovr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            adr_q  <= 1'b0;
        end else if (commit) begin
            data_q <= word;
            adr_q  <= adr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            perr_q <= 1'b0;
            oerr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            full_q <= commit | (full_q & ~rd_data);
            perr_q <= (flag_stb & perr_hit) | (perr_q & ~clr_err);
            ferr_q <= (flag_stb & ferr_hit) | (ferr_q & ~clr_err);
            oerr_q <= (flag_stb & full_q)   | (oerr_q & ~clr_err);
            if (flag_stb) ovr_q <= full_q;
            irq_q  <= rie & (full_q | perr_q | oerr_q | ferr_q);
        end
    end

    assign data_out = data_q;
    assign adr_out  = adr_q;
    assign full     = full_q;
    assign perr     = perr_q;
    assign oerr     = oerr_q;
    assign ferr     = ferr_q;
    assign irq      = irq_q;

endmodule

// File: rtl/mmode_uart_rx.sv
module mmode_uart_rx #(
    parameter int DW          = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_in,
    input  logic          sclk_in,
    input  logic [1:0]    mode,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          rie,
    input  logic          rd_data,
    input  logic          clr_err,
    output logic [DW-1:0] data_out,
    output logic          adr_bit,
    output logic          full,
    output logic          perr,
    output logic          oerr,
    output logic          ferr,
    output logic          irq
);

    logic          rx_s, sclk_rise;
    logic          flag_stb, load_stb, perr_hit, ferr_hit, adr_raw;
    logic [DW-1:0] word;

    rxm_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .sclk_in   (sclk_in),
        .rx_s      (rx_s),
        .sclk_rise (sclk_rise)
    );

    rxm_fsm #(.DW(DW), .OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rx_s      (rx_s),
        .sclk_rise (sclk_rise),
        .mode      (mode),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .flag_stb  (flag_stb),
        .load_stb  (load_stb),
        .perr_hit  (perr_hit),
        .ferr_hit  (ferr_hit),
        .word      (word),
        .adr_bit   (adr_raw)
    );

    rxm_flags #(.DW(DW)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_stb (flag_stb),
        .load_stb (load_stb),
        .perr_hit (perr_hit),
        .ferr_hit (ferr_hit),
        .word     (word),
        .adr_in   (adr_raw),
        .rd_data  (rd_data),
        .clr_err  (clr_err),
        .rie      (rie),
        .data_out (data_out),
        .adr_out  (adr_bit),
        .full     (full),
        .perr     (perr),
        .oerr     (oerr),
        .ferr     (ferr),
        .irq      (irq)
    );

endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          rie,
    input logic [DW-1:0] data_out,
    input logic          full,
    input logic          perr,
    input logic          oerr,
    input logic          ferr,
    input logic          irq
);

    a_r3_err_before_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> (!$rose(perr) && !$rose(ferr) && !$rose(oerr)));

    a_r4_perr_mode0_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr) |-> ($past(mode) == 2'd0));

    a_r6_ferr_async_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr) |-> !$past(mode[1]));

    a_r7_oerr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> $past(full));

    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(full) |-> $stable(data_out));

    a_r11_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(rie && (full || perr || oerr || ferr)));

endmodule

bind mmode_uart_rx rxm_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .rie      (rie),
    .data_out (data_out),
    .full     (full),
    .perr     (perr),
    .oerr     (oerr),
    .ferr     (ferr),
    .irq      (irq)
);

// File: tb/sim_mmode_uart_rx.sv
`timescale 1ns/1ps
module sim_mmode_uart_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic       sclk_in = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rie = 1'b0;
    logic       rd_data = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] data_out;
    logic       adr_bit, full, perr, oerr, ferr, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int t_full  = 0;
    int t_err   = 0;
    int t_irq   = 0;
    logic full_p = 1'b0, err_p = 1'b0, irq_p = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mmode_uart_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in), .sclk_in(sclk_in),
        .mode(mode), .par_en(par_en), .par_odd(par_odd), .rie(rie), .rd_data(rd_data),
        .clr_err(clr_err), .data_out(data_out), .adr_bit(adr_bit), .full(full),
        .perr(perr), .oerr(oerr), .ferr(ferr), .irq(irq)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // record the cycle of the latest rising edge of each output group
    always @(negedge clk) begin
        if (full && !full_p) t_full = cyc;
        if ((perr || oerr || ferr) && !err_p) t_err = cyc;
        if (irq && !irq_p) t_irq = cyc;
        full_p = full;
        err_p  = perr || oerr || ferr;
        irq_p  = irq;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic abit(input logic b);
        rx_in = b;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_async(input logic [7:0] slots, input logic has_adr,
                              input logic adr, input logic stop);
        abit(1'b0);
        for (int i = 0; i < 8; i++) abit(slots[i]);
        if (has_adr) abit(adr);
        abit(stop);
        rx_in = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_sync(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            rx_in = d[i];
            repeat (4) @(negedge clk);
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
            sclk_in = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic clear_all();
        rd_data = 1'b1;
        clr_err = 1'b1;
        @(negedge clk);
        rd_data = 1'b0;
        clr_err = 1'b0;
        @(negedge clk);
    endtask

    // packed status {full, perr, oerr, ferr, adr_bit, data_out}
    function automatic logic [12:0] st();
        return {full, perr, oerr, ferr, adr_bit, data_out};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset state", {19'd0, st()}, 32'd0);
        chk("R12 reset irq", {31'd0, irq}, 32'd0);

        // R1: mode 0, no parity, every byte
        mode = 2'd0; par_en = 1'b0;
        for (int v = 0; v < 256; v++) begin
            send_async(8'(v), 1'b0, 1'b0, 1'b1);
            chk("R1 async normal byte", {19'd0, st()}, {19'd0, 1'b1, 4'b0000, 8'(v)});
            clear_all();
        end

        // R4: parity even/odd, good and bad
        par_en = 1'b1;
        for (int odd = 0; odd < 2; odd++) begin
            for (int bad = 0; bad < 2; bad++) begin
                for (int v = 0; v < 128; v += 4) begin
                    logic p;
                    par_odd = odd[0];
                    p = (^v[6:0]) ^ odd[0] ^ bad[0];
                    send_async({p, v[6:0]}, 1'b0, 1'b0, 1'b1);
                    chk("R4 parity frame", {19'd0, st()},
                        {19'd0, 1'b1, bad[0], 3'b000, 1'b0, v[6:0]});
                    clear_all();
                end
            end
        end

        // R5: multiprocessor, marker captured, parity ignored
        mode = 2'd1; par_en = 1'b1; par_odd = 1'b0;
        for (int a = 0; a < 2; a++) begin
            for (int v = 1; v < 256; v += 4) begin
                send_async(8'(v), 1'b1, a[0], 1'b1);
                chk("R5 multiprocessor frame", {19'd0, st()},
                    {19'd0, 1'b1, 3'b000, a[0], 8'(v)});
                clear_all();
            end
        end

        // R2/R6: synchronous, every byte, parity enabled but unused
        mode = 2'd2; par_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send_sync(8'(v));
            chk("R2 R6 sync byte", {19'd0, st()}, {19'd0, 1'b1, 4'b0000, 8'(v)});
            clear_all();
        end

        // R6/R7: synchronous overrun
        send_sync(8'h3C);
        send_sync(8'hC3);
        chk("R6 R7 sync overrun", {19'd0, st()}, {19'd0, 5'b10100, 8'h3C});
        clear_all();

        // R8/R3/R11: framing error with interrupts enabled
        mode = 2'd0; par_en = 1'b0; rie = 1'b1;
        send_async(8'h5A, 1'b0, 1'b0, 1'b0);
        chk("R8 framing error", {19'd0, st()}, {19'd0, 5'b10010, 8'h5A});
        chk("R3 error precedes full", t_full - t_err, 1);
        chk("R11 irq one cycle after error", t_irq - t_err, 1);
        clear_all();
        @(negedge clk);
        chk("R11 irq drops after clear", {31'd0, irq}, 32'd0);

        // R3: parity error ordering
        par_en = 1'b1;
        send_async({~(^7'h11), 7'h11}, 1'b0, 1'b0, 1'b1);
        chk("R3 parity before full", t_full - t_err, 1);
        clear_all();
        @(negedge clk);

        // R11: clean frame, irq one cycle after full
        par_en = 1'b0;
        send_async(8'h81, 1'b0, 1'b0, 1'b1);
        chk("R11 irq one cycle after full", t_irq - t_full, 1);
        clear_all();
        rie = 1'b0;
        send_async(8'h42, 1'b0, 1'b0, 1'b1);
        chk("R11 irq stays low when disabled", {31'd0, irq}, 32'd0);

        // R7/R10: async overrun then separate clears
        send_async(8'hE7, 1'b0, 1'b0, 1'b1);
        chk("R7 old byte kept on overrun", {19'd0, st()}, {19'd0, 5'b10100, 8'h42});
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
        chk("R10 clr_err clears errors only", {19'd0, st()}, {19'd0, 5'b10000, 8'h42});
        rd_data = 1'b1; @(negedge clk); rd_data = 1'b0; @(negedge clk);
        chk("R10 rd_data clears full only", {19'd0, st()}, {19'd0, 5'b00000, 8'h42});

        // R9: short glitch ignored, then a valid frame
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        chk("R9 glitch not received", {31'd0, full}, 32'd0);
        send_async(8'h99, 1'b0, 1'b0, 1'b1);
        chk("R9 frame after glitch", {19'd0, st()}, {19'd0, 5'b10000, 8'h99});

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule